// File: doc/BRIEF.md
# SD Data Path Control Register

This block is the firmware-facing control register for the data path of an SD/MMC host controller. It also holds the small amount of control logic that sits around the data path state machine. Firmware writes a control word and a data-length word over a plain single-cycle register bus. The data path reports back whether it is active, whether the current transfer has finished, whether a transfer error or a transfer hold is present, and when it leaves its read-wait state.

Most control fields are guarded. They accept new values only while the data path is idle. The read-wait start and stop bits can be written at any time. Hardware clears the transfer enable bit when a transfer finishes, and clears the read-wait stop bit when the state machine leaves read-wait. A FIFO flush request turns into a one-cycle flush pulse, but only when every qualifying condition holds in the cycle of the write.

The block also computes the number of bytes a transfer will really move. In block mode the programmed length is cut down to a whole number of blocks, and two illegal size settings yield zero. Card signalling, CRC, the FIFO storage and the DMA engine are all outside this block.

Top module: `sdp_ctrl_top`

## Requirements
- R1: A control write (reg_sel=0) updates the guarded fields only while dpath_active is 0. The guarded fields are: transfer enable (bit 0), receive direction (bit 1), stream mode (bit 2), block size code (bits 7:4), read-wait mode (bit 10), SDIO interrupt enable (bit 11) and boot-acknowledge enable (bit 12). While dpath_active is 1 these fields keep their values.
- R2: xfer_done clears xfer_en in the next cycle. This also holds when a write sets the enable bit in the same cycle.
- R3: A control write with bit 13 set is a FIFO flush request. It is accepted only when dma_en is 0 and dpath_active is 1.
- R4: An accepted flush request produces fifo_flush only if xfer_err or xfer_hold is 1 in the cycle of the write. fifo_flush is then high for exactly the one cycle after the write. In every other case the request has no effect.
- R5: Read-wait start (bit 8) and read-wait stop (bit 9) take the written value on any control write, whatever the value of dpath_active.
- R6: rw_leave clears rw_stop in the next cycle. This clear overrides a write in the same cycle.
- R7: In block mode (stream_mode=0) with a code from 0 to 14, eff_len equals the length register with its low `code` bits forced to zero. The block size is 2^code bytes.
- R8: In block mode with ddr_en=1, block size code 0 gives eff_len of 0.
- R9: In block mode, block size code 15 is reserved and gives eff_len of 0.
- R10: In stream mode, eff_len equals the length register unchanged.
- R11: A length write (reg_sel=1) loads bits 24:0 of reg_wdata at any time.
- R12: After reset every control output, fifo_flush and eff_len are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = data length |
| reg_wdata | input | 32 | Write data |
| dpath_active | input | 1 | Data path state machine is active |
| dma_en | input | 1 | Internal DMA enabled |
| ddr_en | input | 1 | Double data rate signalling selected |
| xfer_done | input | 1 | Data transfer completed |
| xfer_err | input | 1 | Transfer error present |
| xfer_hold | input | 1 | Transfer hold present |
| rw_leave | input | 1 | State machine leaves read-wait for wait-receive or idle |
| xfer_en | output | 1 | Transfer enable |
| dir_rx | output | 1 | Direction: 1 = card to host |
| stream_mode | output | 1 | 1 = stream mode, 0 = block mode |
| blk_code | output | 4 | Block size code |
| rw_mode | output | 1 | Read-wait mode select |
| rw_start | output | 1 | Read-wait start |
| rw_stop | output | 1 | Read-wait stop |
| irq_en | output | 1 | SDIO interrupt enable |
| bootack_en | output | 1 | Boot acknowledge reception enable |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| eff_len | output | 25 | Effective transfer length in bytes |

## Verification
The bench builds the block with its default parameters: a 25-bit length and a 4-bit size code. With these values every size code from 0 to the reserved 15 can be reached. So can the widest masking case, where an all-ones length loses only its low bits. The bench steps through all eight combinations of active flag, DMA enable and error-or-hold for the flush path. Each guarded field is tested both while the data path is active and while it is idle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int CODE_W      = 4;
  localparam int MAX_CODE    = 14;
  localparam int B_EN        = 0;
  localparam int B_DIR       = 1;
  localparam int B_STREAM    = 2;
  localparam int B_CODE_LSB  = 4;
  localparam int B_RWSTART   = 8;
  localparam int B_RWSTOP    = 9;
  localparam int B_RWMODE    = 10;
  localparam int B_IRQ       = 11;
  localparam int B_BOOT      = 12;
  localparam int B_FLUSH     = 13;

  typedef struct packed {
    logic              en;
    logic              dir;
    logic              stream;
    logic [CODE_W-1:0] code;
    logic              rw_mode;
    logic              irq_en;
    logic              boot_en;
  } guarded_t;
endpackage

// File: rtl/sdp_field_regs.sv
module sdp_field_regs
  import sdp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              active,
  input  logic              done,
  input  logic              rw_leave,
  output guarded_t          gf,
  output logic              rw_start,
  output logic              rw_stop
);
  guarded_t gf_q;
  guarded_t gf_new;

  always_comb begin
    gf_new.en      = wdata[B_EN];
    gf_new.dir     = wdata[B_DIR];
    gf_new.stream  = wdata[B_STREAM];
    gf_new.code    = wdata[B_CODE_LSB +: CODE_W];
    gf_new.rw_mode = wdata[B_RWMODE];
    gf_new.irq_en  = wdata[B_IRQ];
    gf_new.boot_en = wdata[B_BOOT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gf_q     <= '0;
      rw_start <= 1'b0;
      rw_stop  <= 1'b0;
    end else begin
      if (ctl_wr && !active) gf_q <= gf_new;
      if (done) gf_q.en <= 1'b0;
      if (ctl_wr) begin
        rw_start <= wdata[B_RWSTART];
        rw_stop  <= wdata[B_RWSTOP];
      end
      if (rw_leave) rw_stop <= 1'b0;
    end
  end

  assign gf = gf_q;
endmodule

// File: rtl/sdp_flush_gen.sv
module sdp_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic active,
  input  logic dma_en,
  input  logic err,
  input  logic hold,
  output logic flush
);
  logic accept;
  assign accept = req && active && !dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush <= 1'b0;
    else        flush <= accept && (err || hold);
  end
endmodule

// File: rtl/sdp_len_calc.sv
module sdp_len_calc
  import sdp_pkg::*;
#(
  parameter int LEN_W = 25
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [CODE_W-1:0] code,
  input  logic              stream,
  input  logic              ddr,
  output logic [LEN_W-1:0]  eff
);
  logic [LEN_W-1:0] keep;
  logic             illegal;

  for (genvar i = 0; i < LEN_W; i++) begin : g_mask
    assign keep[i] = (i >= int'(code));
  end

  assign illegal = (int'(code) > MAX_CODE) || (ddr && code == '0);

  always_comb begin
    if (stream)       eff = len;
    else if (illegal) eff = '0;
    else              eff = len & keep;
  end
endmodule

// File: rtl/sdp_ctrl_top.sv
module sdp_ctrl_top
  import sdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              dpath_active,
  input  logic              dma_en,
  input  logic              ddr_en,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic              xfer_hold,
  input  logic              rw_leave,
  output logic              xfer_en,
  output logic              dir_rx,
  output logic              stream_mode,
  output logic [CODE_W-1:0] blk_code,
  output logic              rw_mode,
  output logic              rw_start,
  output logic              rw_stop,
  output logic              irq_en,
  output logic              bootack_en,
  output logic              fifo_flush,
  output logic [LEN_W-1:0]  eff_len
);
  logic             ctl_wr;
  logic             len_wr;
  logic [LEN_W-1:0] len_q;
  guarded_t         gf;

  assign ctl_wr = reg_wr && !reg_sel;
  assign len_wr = reg_wr &&  reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_wr) len_q <= reg_wdata[LEN_W-1:0];
  end

  sdp_field_regs #(.DATA_W(DATA_W)) u_fields (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(reg_wdata),
    .active(dpath_active), .done(xfer_done), .rw_leave(rw_leave),
    .gf(gf), .rw_start(rw_start), .rw_stop(rw_stop)
  );

  sdp_flush_gen u_flush (
    .clk(clk), .rst_n(rst_n), .req(ctl_wr && reg_wdata[B_FLUSH]),
    .active(dpath_active), .dma_en(dma_en), .err(xfer_err),
    .hold(xfer_hold), .flush(fifo_flush)
  );

  sdp_len_calc #(.LEN_W(LEN_W)) u_len (
    .len(len_q), .code(gf.code), .stream(gf.stream), .ddr(ddr_en),
    .eff(eff_len)
  );

  assign xfer_en     = gf.en;
  assign dir_rx      = gf.dir;
  assign stream_mode = gf.stream;
  assign blk_code    = gf.code;
  assign rw_mode     = gf.rw_mode;
  assign irq_en      = gf.irq_en;
  assign bootack_en  = gf.boot_en;
endmodule

// File: rtl/sdp_ctrl_chk.sv
module sdp_ctrl_chk
  import sdp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dpath_active,
  input logic              dma_en,
  input logic              ddr_en,
  input logic              xfer_done,
  input logic              xfer_err,
  input logic              xfer_hold,
  input logic              rw_leave,
  input logic              xfer_en,
  input logic              dir_rx,
  input logic              stream_mode,
  input logic [CODE_W-1:0] blk_code,
  input logic              rw_mode,
  input logic              rw_stop,
  input logic              irq_en,
  input logic              bootack_en,
  input logic              fifo_flush,
  input logic [LEN_W-1:0]  eff_len
);
  logic [LEN_W-1:0] low_bits;
  always_comb low_bits = (LEN_W'(1) << blk_code) - LEN_W'(1);

  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dpath_active |=> $stable({dir_rx, stream_mode, blk_code, rw_mode, irq_en, bootack_en})); // R1

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_en); // R2

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(reg_wr && !reg_sel && reg_wdata[B_FLUSH] && dpath_active && !dma_en)); // R3

  AST_FLUSH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(xfer_err || xfer_hold)); // R4

  AST_RWSTOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    rw_leave |=> !rw_stop); // R6

  always_comb begin
    if (rst_n && !stream_mode && int'(blk_code) <= MAX_CODE)
      AST_BLOCK_ALIGN: assert ((eff_len & low_bits) == '0); // R7
    if (rst_n && !stream_mode && ddr_en && blk_code == '0)
      AST_DDR_ZERO: assert (eff_len == '0); // R8
    if (rst_n && !stream_mode && int'(blk_code) > MAX_CODE)
      AST_RSVD_ZERO: assert (eff_len == '0); // R9
  end
endmodule

bind sdp_ctrl_top sdp_ctrl_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .dpath_active(dpath_active), .dma_en(dma_en),
  .ddr_en(ddr_en), .xfer_done(xfer_done), .xfer_err(xfer_err),
  .xfer_hold(xfer_hold), .rw_leave(rw_leave), .xfer_en(xfer_en),
  .dir_rx(dir_rx), .stream_mode(stream_mode), .blk_code(blk_code),
  .rw_mode(rw_mode), .rw_stop(rw_stop), .irq_en(irq_en),
  .bootack_en(bootack_en), .fifo_flush(fifo_flush), .eff_len(eff_len)
);

// File: tb/test_sdp_ctrl_top.sv
module test_sdp_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        dpath_active = 1'b0, dma_en = 1'b0, ddr_en = 1'b0;
  logic        xfer_done = 1'b0, xfer_err = 1'b0, xfer_hold = 1'b0, rw_leave = 1'b0;
  logic        xfer_en, dir_rx, stream_mode, rw_mode, rw_start, rw_stop;
  logic        irq_en, bootack_en, fifo_flush;
  logic [3:0]  blk_code;
  logic [24:0] eff_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sdp_ctrl_top i_sdp_ctrl_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dpath_active(dpath_active), .dma_en(dma_en),
    .ddr_en(ddr_en), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .xfer_hold(xfer_hold), .rw_leave(rw_leave), .xfer_en(xfer_en),
    .dir_rx(dir_rx), .stream_mode(stream_mode), .blk_code(blk_code),
    .rw_mode(rw_mode), .rw_start(rw_start), .rw_stop(rw_stop),
    .irq_en(irq_en), .bootack_en(bootack_en), .fifo_flush(fifo_flush),
    .eff_len(eff_len)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic        ddr;
    logic        stream;
    logic [24:0] len;
    logic [24:0] exp;
  } lvec_t;

  localparam lvec_t LV [10] = '{
    '{4'd9,  1'b0, 1'b0, 25'd1300,     25'd1024},     // R7
    '{4'd0,  1'b0, 1'b0, 25'd7,        25'd7},        // R7
    '{4'd0,  1'b1, 1'b0, 25'd7,        25'd0},        // R8
    '{4'd15, 1'b0, 1'b0, 25'd1000,     25'd0},        // R9
    '{4'd3,  1'b0, 1'b0, 25'h1FFFFFF,  25'h1FFFFF8},  // R7
    '{4'd9,  1'b0, 1'b1, 25'd1300,     25'd1300},     // R10
    '{4'd14, 1'b0, 1'b0, 25'd20000,    25'd16384},    // R7
    '{4'd2,  1'b1, 1'b0, 25'd10,       25'd8},        // R7
    '{4'd9,  1'b0, 1'b0, 25'd511,      25'd0},        // R7
    '{4'd15, 1'b1, 1'b1, 25'd77,       25'd77}        // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ctrl", {xfer_en, dir_rx, stream_mode, blk_code, rw_mode, rw_start,
                     rw_stop, irq_en, bootack_en, fifo_flush}, '0);
    chk("R12 len", eff_len, '0);

    for (int i = 0; i < 10; i++) begin
      ddr_en = LV[i].ddr;
      wr(1'b1, 32'(LV[i].len));
      wr(1'b0, (32'(LV[i].code) << 4) | (32'(LV[i].stream) << 2));
      chk($sformatf("R7-vector%0d", i), eff_len, LV[i].exp);
    end
    ddr_en = 1'b0;

    // R11: a length write while active is accepted; block code 9 in place
    wr(1'b0, 32'h90);
    dpath_active = 1'b1;
    wr(1'b1, 32'd2000);
    chk("R11", eff_len, 25'd1536);

    // R1: all guarded bits written while active are kept; R5: read-wait bits taken
    wr(1'b0, 32'h1FF7);
    chk("R1", {xfer_en, dir_rx, stream_mode, blk_code, rw_mode, irq_en, bootack_en},
        {1'b0, 1'b0, 1'b0, 4'd9, 1'b0, 1'b0, 1'b0});
    chk("R5", {rw_start, rw_stop}, 2'b11);

    // R6: rw_leave clears stop, wins over a same-cycle write
    @(negedge clk);
    rw_leave = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h300;
    @(negedge clk);
    rw_leave = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R6", {rw_start, rw_stop}, 2'b10);

    // R1: accepted when idle
    dpath_active = 1'b0;
    wr(1'b0, 32'h1C03);
    chk("R1 idle", {xfer_en, dir_rx, rw_mode, irq_en, bootack_en}, 5'b11111);

    // R2: done clears enable
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk("R2", xfer_en, 1'b0);
    // R2: done wins over same-cycle enable write
    @(negedge clk);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h1;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R2 same-cycle", xfer_en, 1'b0);

    // R3/R4: all active/dma/error combinations
    for (int k = 0; k < 8; k++) begin
      dpath_active = k[2]; dma_en = k[1]; xfer_err = k[0];
      wr(1'b0, 32'h2000);
      chk($sformatf("R3-R4 combo%0d", k), fifo_flush, k[2] & ~k[1] & k[0]);
      @(negedge clk);
      chk("R4 pulse", fifo_flush, 1'b0);
    end
    // R4: hold alone qualifies
    dpath_active = 1'b1; dma_en = 1'b0; xfer_err = 1'b0; xfer_hold = 1'b1;
    wr(1'b0, 32'h2000);
    chk("R4 hold", fifo_flush, 1'b1);
    xfer_hold = 1'b0;
    // R3: no request bit, no flush
    xfer_err = 1'b1;
    wr(1'b0, 32'h0);
    chk("R3 nobit", fifo_flush, 1'b0);
    xfer_err = 1'b0; dpath_active = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule